// File: doc/BRIEF.md
# Hitless Reference Switch Offset Controller

This block sits between two digitized phase-detector streams and the digital loop filter of a clock-cleaning PLL. Each reference input delivers a signed phase-error sample every clock. The block keeps a fine phase offset for each input and forwards only the active input's error minus its offset. When the active input changes, the offset of the incoming input is loaded with that input's present error. The loop therefore sees no phase step from the change itself, as long as both reference frequencies hold steady.

A change of input comes from a one-cycle manual request or from loss-of-signal on the active input. A change is refused whenever the other input is also reporting loss-of-signal. A background auto-zero process runs on a fixed divider tick. On each tick it moves the fine offset by a fixed step toward zero and moves a per-input coarse offset DAC code one count the other way, so the fine register does not overflow. Each input also keeps a modulo-8 wrap index. This index counts sample-to-sample jumps larger than half the detector range, which is how offsets beyond the detector span are tracked.

Top module: `refsw_offset_ctrl`

## Requirements
- R1: One clock after a sample, `loop_err_o` equals the active input's error sample minus that input's fine offset after the same edge, as a signed PW+1 bit value.
- R2: On a switch, the incoming input's fine offset is loaded with its present error, clipped to the fine range. The next `loop_err_o` is therefore zero unless clipping occurred.
- R3: Loss-of-signal on the active input with the other input clear switches inputs at the next edge; `act_b_o` is 0 for input A and 1 for input B.
- R4: A manual request (`man_req_i` high for a cycle) switches to the other input, unless that input reports loss-of-signal. In that case the active input is unchanged.
- R5: Every AZ_DIV cycles, on a non-capturing input: a fine offset of at least STEP loses STEP and the coarse code rises by 1; a fine offset of -STEP or less gains STEP and the code falls by 1. No move happens when the code is at its signed CW-bit limit in that direction.
- R6: When a capture and an auto-zero tick fall on the same input in the same cycle, the capture wins and that input's coarse code does not move.
- R7: For each input, a sample-to-sample difference below -2^(PW-1) adds 1 to its wrap index, and one above +2^(PW-1) subtracts 1, both modulo 8. The previous sample resets to 0. `wrap_idx_o` shows the active input's index.
- R8: The fine offset is signed OW bits and saturates on capture. `fine_sat_o` is high while the active fine offset sits at either end of the range.
- R9: Reset selects input A and clears all offsets, codes, wrap indices, the tick divider and `loop_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | sample clock |
| rst_ni | input | 1 | asynchronous active-low reset |
| pe_a_i | input | PW | signed phase-error sample, input A |
| pe_b_i | input | PW | signed phase-error sample, input B |
| los_a_i | input | 1 | loss-of-signal, input A |
| los_b_i | input | 1 | loss-of-signal, input B |
| man_req_i | input | 1 | manual request to change input |
| loop_err_o | output | PW+1 | signed error to the loop filter |
| act_b_o | output | 1 | active input (0 = A, 1 = B) |
| coarse_a_o | output | CW | signed coarse DAC code, input A |
| coarse_b_o | output | CW | signed coarse DAC code, input B |
| wrap_idx_o | output | 3 | wrap index of the active input |
| fine_sat_o | output | 1 | active fine offset at a range limit |

## Verification
Two functions can land on the same input in the same cycle: the capture made by an input change, and the auto-zero tick that moves offset into the coarse code. The bench tracks the tick divider in its own model and issues a manual request exactly on a tick cycle. It then checks that the coarse code of the captured input did not move and that the following tick does move it. The same per-cycle model is also run against long streams of random samples, requests and loss-of-signal patterns. In those streams, ticks, captures and wraps overlap freely, and every output is compared on every clock.

// File: rtl/refsw_pkg.sv
package refsw_pkg;
  localparam int NUM_REF  = 2;
  localparam int WRAP_MOD = 8;
  localparam int WRAP_W   = $clog2(WRAP_MOD);

  typedef enum logic {REF_A = 1'b0, REF_B = 1'b1} ref_sel_e;
  typedef logic [WRAP_W-1:0] wrap_idx_t;
endpackage

// File: rtl/refsw_select.sv
module refsw_select
  import refsw_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     los_a_i,
  input  logic     los_b_i,
  input  logic     man_req_i,
  output ref_sel_e act_o,
  output ref_sel_e act_nx_o,
  output logic     sw_o
);
  ref_sel_e act_q, act_n;
  logic     los_cur, los_tgt, sw;

  // next-state
  always_comb begin
    los_cur = (act_q == REF_A) ? los_a_i : los_b_i;
    los_tgt = (act_q == REF_A) ? los_b_i : los_a_i;
    sw      = !los_tgt && (los_cur || man_req_i);
    act_n   = act_q;
    if (sw) begin
      act_n = (act_q == REF_A) ? REF_B : REF_A;
    end
  end

  // register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= REF_A;
    end else begin
      act_q <= act_n;
    end
  end

  assign act_o    = act_q;
  assign act_nx_o = act_n;
  assign sw_o     = sw;

  // R3: loss on the active input with the other clear forces a change
  a_r3_los_switch_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q == REF_A && los_a_i && !los_b_i) |=> (act_q == REF_B));
  a_r3_los_switch_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q == REF_B && los_b_i && !los_a_i) |=> (act_q == REF_A));
  // R4: a target in loss-of-signal blocks any change
  a_r4_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    los_tgt |=> (act_q == $past(act_q)));
endmodule

// File: rtl/refsw_chan.sv
module refsw_chan
  import refsw_pkg::*;
#(
  parameter int PW   = 10,
  parameter int OW   = 8,
  parameter int CW   = 6,
  parameter int STEP = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [PW-1:0] pe_i,
  input  logic                 cap_i,
  input  logic                 tick_i,
  output logic signed [OW-1:0] off_o,
  output logic signed [OW-1:0] off_nx_o,
  output logic signed [CW-1:0] code_o,
  output wrap_idx_t            wrap_o
);
  localparam int OMAX = 2**(OW-1) - 1;
  localparam int OMIN = -(2**(OW-1));
  localparam int CMAX = 2**(CW-1) - 1;
  localparam int CMIN = -(2**(CW-1));
  localparam int HALF = 2**(PW-1);

  logic signed [OW-1:0] off_q, off_n;
  logic signed [CW-1:0] code_q, code_n;
  logic signed [PW-1:0] prev_q;
  wrap_idx_t            wrap_q, wrap_n;
  int                   pe_int, off_int, code_int, delta;

  // next-state
  always_comb begin
    pe_int   = int'(pe_i);
    off_int  = int'(off_q);
    code_int = int'(code_q);
    off_n    = off_q;
    code_n   = code_q;
    if (cap_i) begin
      if (pe_int > OMAX) begin
        off_n = OW'(OMAX);
      end else if (pe_int < OMIN) begin
        off_n = OW'(OMIN);
      end else begin
        off_n = OW'(pe_int);
      end
    end else if (tick_i) begin
      if (off_int >= STEP && code_int < CMAX) begin
        off_n  = OW'(off_int - STEP);
        code_n = CW'(code_int + 1);
      end else if (off_int <= -STEP && code_int > CMIN) begin
        off_n  = OW'(off_int + STEP);
        code_n = CW'(code_int - 1);
      end
    end
    delta  = pe_int - int'(prev_q);
    wrap_n = wrap_q;
    if (delta < -HALF) begin
      wrap_n = wrap_q + WRAP_W'(1);
    end else if (delta > HALF) begin
      wrap_n = wrap_q - WRAP_W'(1);
    end
  end

  // register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q  <= '0;
      code_q <= '0;
      prev_q <= '0;
      wrap_q <= '0;
    end else begin
      off_q  <= off_n;
      code_q <= code_n;
      prev_q <= pe_i;
      wrap_q <= wrap_n;
    end
  end

  assign off_o    = off_q;
  assign off_nx_o = off_n;
  assign code_o   = code_q;
  assign wrap_o   = wrap_q;

  // R5: a large positive fine offset on a tick moves the coarse code up by one
  a_r5_code_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !cap_i && int'(off_q) >= STEP && int'(code_q) < CMAX)
      |=> (int'(code_q) == int'($past(code_q)) + 1));
  // R6: capture on a tick leaves the coarse code alone
  a_r6_capture_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && tick_i) |=> (code_q == $past(code_q)));
  // R7: the wrap index moves by at most one per sample
  a_r7_wrap_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> (wrap_q == $past(wrap_q) || wrap_q == $past(wrap_q) + WRAP_W'(1)
                || wrap_q == $past(wrap_q) - WRAP_W'(1)));
endmodule

// File: rtl/refsw_offset_ctrl.sv
module refsw_offset_ctrl
  import refsw_pkg::*;
#(
  parameter int PW     = 10,
  parameter int OW     = 8,
  parameter int CW     = 6,
  parameter int STEP   = 16,
  parameter int AZ_DIV = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [PW-1:0] pe_a_i,
  input  logic signed [PW-1:0] pe_b_i,
  input  logic                 los_a_i,
  input  logic                 los_b_i,
  input  logic                 man_req_i,
  output logic signed [PW:0]   loop_err_o,
  output logic                 act_b_o,
  output logic signed [CW-1:0] coarse_a_o,
  output logic signed [CW-1:0] coarse_b_o,
  output logic [WRAP_W-1:0]    wrap_idx_o,
  output logic                 fine_sat_o
);
  localparam int EW   = PW + 1;
  localparam int AZ_W = (AZ_DIV > 1) ? $clog2(AZ_DIV) : 1;
  localparam int OMAX = 2**(OW-1) - 1;
  localparam int OMIN = -(2**(OW-1));

  ref_sel_e             act_q, act_n;
  logic                 sw, tick;
  logic [AZ_W-1:0]      az_cnt_q, az_cnt_n;
  logic signed [EW-1:0] err_q, err_n;
  logic signed [PW-1:0] pe_arr     [NUM_REF];
  logic signed [OW-1:0] off_arr    [NUM_REF];
  logic signed [OW-1:0] off_nx_arr [NUM_REF];
  logic signed [CW-1:0] code_arr   [NUM_REF];
  wrap_idx_t            wrap_arr   [NUM_REF];
  logic [NUM_REF-1:0]   cap;

  assign pe_arr[0] = pe_a_i;
  assign pe_arr[1] = pe_b_i;

  refsw_select u_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .los_a_i   (los_a_i),
    .los_b_i   (los_b_i),
    .man_req_i (man_req_i),
    .act_o     (act_q),
    .act_nx_o  (act_n),
    .sw_o      (sw)
  );

  // auto-zero divider, next-state
  always_comb begin
    tick     = (az_cnt_q == AZ_W'(AZ_DIV - 1));
    az_cnt_n = tick ? '0 : az_cnt_q + AZ_W'(1);
  end

  always_comb begin
    cap[0] = sw && (act_n == REF_A);
    cap[1] = sw && (act_n == REF_B);
  end

  for (genvar g = 0; g < NUM_REF; g++) begin : g_chan
    refsw_chan #(.PW(PW), .OW(OW), .CW(CW), .STEP(STEP)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pe_i     (pe_arr[g]),
      .cap_i    (cap[g]),
      .tick_i   (tick),
      .off_o    (off_arr[g]),
      .off_nx_o (off_nx_arr[g]),
      .code_o   (code_arr[g]),
      .wrap_o   (wrap_arr[g])
    );
  end

  // loop error, next-state
  always_comb begin
    err_n = EW'(pe_arr[act_n]) - EW'(off_nx_arr[act_n]);
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      az_cnt_q <= '0;
      err_q    <= '0;
    end else begin
      az_cnt_q <= az_cnt_n;
      err_q    <= err_n;
    end
  end

  assign loop_err_o = err_q;
  assign act_b_o    = (act_q == REF_B);
  assign coarse_a_o = code_arr[0];
  assign coarse_b_o = code_arr[1];
  assign wrap_idx_o = wrap_arr[act_q];
  assign fine_sat_o = (int'(off_arr[act_q]) == OMAX) || (int'(off_arr[act_q]) == OMIN);

  // R2: a capture without clipping yields a zero loop error at the next edge
  a_r2_hitless: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw && (int'(pe_arr[act_n]) <= OMAX) && (int'(pe_arr[act_n]) >= OMIN))
      |=> (loop_err_o == '0));
endmodule

// File: tb/refsw_offset_ctrl_tb_top.sv
module refsw_offset_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 10, OW = 8, CW = 6, STEP = 16, AZ_DIV = 8;
  localparam int OMAX = 2**(OW-1) - 1, OMIN = -(2**(OW-1));
  localparam int CMAX = 2**(CW-1) - 1, CMIN = -(2**(CW-1));
  localparam int HALF = 2**(PW-1);

  logic clk = 1'b0;
  logic rst_ni;
  logic signed [PW-1:0] pe_a, pe_b;
  logic los_a, los_b, man_req;
  logic signed [PW:0]   loop_err;
  logic                 act_b;
  logic signed [CW-1:0] coarse_a, coarse_b;
  logic [2:0]           wrap_idx;
  logic                 fine_sat;

  int errors = 0, checks = 0;

  // behavioural model state (values expected after the most recent edge)
  int m_act, m_azc, m_err;
  int m_off[2], m_cd[2], m_k[2], m_prev[2];

  always #(CLK_PERIOD/2) clk = ~clk;

  refsw_offset_ctrl #(.PW(PW), .OW(OW), .CW(CW), .STEP(STEP), .AZ_DIV(AZ_DIV)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .pe_a_i(pe_a), .pe_b_i(pe_b),
    .los_a_i(los_a), .los_b_i(los_b), .man_req_i(man_req),
    .loop_err_o(loop_err), .act_b_o(act_b), .coarse_a_o(coarse_a),
    .coarse_b_o(coarse_b), .wrap_idx_o(wrap_idx), .fine_sat_o(fine_sat)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic int clip(input int v);
    if (v > OMAX) return OMAX;
    if (v < OMIN) return OMIN;
    return v;
  endfunction

  // model of one clock edge from the inputs now applied
  task automatic model_edge();
    int pe[2];
    int tick, los_cur, los_tgt, sw, nact, d;
    pe[0] = int'(pe_a);
    pe[1] = int'(pe_b);
    if (!rst_ni) begin
      m_act = 0; m_azc = 0; m_err = 0;
      for (int c = 0; c < 2; c++) begin
        m_off[c] = 0; m_cd[c] = 0; m_k[c] = 0; m_prev[c] = 0;
      end
      return;
    end
    tick    = (m_azc == AZ_DIV - 1);
    los_cur = (m_act == 0) ? los_a : los_b;
    los_tgt = (m_act == 0) ? los_b : los_a;
    sw      = !los_tgt && (los_cur || man_req);
    nact    = sw ? 1 - m_act : m_act;
    for (int c = 0; c < 2; c++) begin
      if (sw && c == nact) begin
        m_off[c] = clip(pe[c]);
      end else if (tick) begin
        if (m_off[c] >= STEP && m_cd[c] < CMAX) begin
          m_off[c] -= STEP; m_cd[c] += 1;
        end else if (m_off[c] <= -STEP && m_cd[c] > CMIN) begin
          m_off[c] += STEP; m_cd[c] -= 1;
        end
      end
      d = pe[c] - m_prev[c];
      if (d < -HALF) m_k[c] = (m_k[c] + 1) % 8;
      else if (d > HALF) m_k[c] = (m_k[c] + 7) % 8;
      m_prev[c] = pe[c];
    end
    m_azc = tick ? 0 : m_azc + 1;
    m_act = nact;
    m_err = pe[nact] - m_off[nact];
  endtask

  task automatic compare_all();
    chk("R1 loop_err", int'(loop_err), m_err);
    chk("R3 act_b", int'(act_b), m_act);
    chk("R5 coarse_a", int'(coarse_a), m_cd[0]);
    chk("R5 coarse_b", int'(coarse_b), m_cd[1]);
    chk("R7 wrap_idx", int'(wrap_idx), m_k[m_act]);
    chk("R8 fine_sat", int'(fine_sat), int'(m_off[m_act] == OMAX || m_off[m_act] == OMIN));
  endtask

  // inputs are set at a falling edge; one call covers one rising edge
  task automatic cyc();
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    int save_cd, save_k;
    rst_ni = 1'b0; pe_a = '0; pe_b = '0; los_a = 1'b0; los_b = 1'b0; man_req = 1'b0;
    @(negedge clk);
    repeat (3) cyc();
    // R9: reset state
    chk("R9 err", int'(loop_err), 0);
    chk("R9 act", int'(act_b), 0);
    chk("R9 coarse", int'(coarse_a) + int'(coarse_b), 0);
    chk("R9 wrap", int'(wrap_idx), 0);
    rst_ni = 1'b1;
    pe_a = 10'sd40; pe_b = -10'sd30;
    repeat (4) cyc();
    chk("R1 plain error on A", int'(loop_err), 40);

    // R4 and R2: manual change to B is hitless
    man_req = 1'b1; cyc(); man_req = 1'b0;
    chk("R4 manual switch", int'(act_b), 1);
    chk("R2 hitless error", int'(loop_err), 0);

    // R4: request refused while target is in loss-of-signal
    los_a = 1'b1; man_req = 1'b1; cyc(); man_req = 1'b0;
    chk("R4 blocked request", int'(act_b), 1);
    cyc(); los_a = 1'b0; cyc();

    // R3: loss on active B moves to A
    los_b = 1'b1; cyc(); los_b = 1'b0;
    chk("R3 los switch", int'(act_b), 0);
    chk("R3 error after capture", int'(loop_err), 0);
    repeat (3) cyc();

    // R8: capture of a large error saturates the fine offset
    pe_b = 10'sd300; man_req = 1'b1; cyc(); man_req = 1'b0;
    chk("R8 saturated flag", int'(fine_sat), 1);
    chk("R8 clipped error", int'(loop_err), 300 - OMAX);

    // R6: capture on A in the same cycle as the tick
    pe_a = 10'sd200;
    while (m_azc != AZ_DIV - 1) cyc();
    save_cd = m_cd[0];
    man_req = 1'b1; cyc(); man_req = 1'b0;
    chk("R6 capture beats tick", int'(coarse_a), save_cd);
    // R5: the next tick unloads STEP into the coarse code
    repeat (AZ_DIV) cyc();
    chk("R5 coarse step", int'(coarse_a), save_cd + 1);

    // R7: a jump below -HALF bumps the wrap index
    save_k = m_k[0];
    pe_a = -10'sd400; cyc();
    chk("R7 wrap up", int'(wrap_idx), (save_k + 1) % 8);
    pe_a = 10'sd300; cyc();
    chk("R7 wrap down", int'(wrap_idx), save_k);

    // random streams
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 15) == 0) pe_a = PW'($urandom_range(0, 1023) - 512);
      else pe_a = PW'(clip(int'(pe_a) + $urandom_range(0, 8) - 4));
      if ($urandom_range(0, 15) == 0) pe_b = PW'($urandom_range(0, 1023) - 512);
      else pe_b = PW'(int'(pe_b) + (($urandom_range(0, 1) == 0) ? 2 : -2));
      if (int'(pe_b) > 500 || int'(pe_b) < -500) pe_b = '0;
      man_req = ($urandom_range(0, 9) == 0);
      if ($urandom_range(0, 19) == 0) los_a = ~los_a;
      if ($urandom_range(0, 19) == 0) los_b = ~los_b;
      cyc();
    end
    man_req = 1'b0; los_a = 1'b0; los_b = 1'b0;
    cyc();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule